// File: doc/BRIEF.md
# Fixed-Budget Iteration Scheduler

This block decides which code word an external iteration engine works on in each decoding slot. Every code-word interval begins with an arrival pulse and carries a fixed number of iteration slots. A code word is not forced to finish inside its own interval. It stays resident for several intervals, so a rare slow code word can use slots that its easy neighbours leave unused. The cost is a fixed output delay.

Code words sit in a ring of buffers, and the ring is as deep as the latency limit. The code word with arrival index s lives in buffer s mod NBUF. On arrival, that buffer's previous occupant is released to the output. If the occupant never passed its parity check, it is released as a failure. The newcomer then takes the first slot of the interval. A mode input chooses how the remaining slots are shared.

The engine receives a buffer index as a one-cycle grant. It answers with a parity result. The scheduler waits for that answer before it issues the next grant, so a slot freed by a pass goes to another buffer within the same interval.

Top module: `iter_slot_sched`

## Requirements
- R1: After reset, no grant and no output are presented until the first arrival.
- R2: The code word with arrival index s is placed in buffer s mod NBUF. The first grant after its arrival goes to that buffer.
- R3: An interval issues at most BUDGET grants. Only one grant is outstanding at a time, and the next grant waits until a result has been returned.
- R4: A buffer whose result reported a parity pass receives no further grant.
- R5: With mode_i = 1 (oldest-only), every slot after the first goes to the active buffer that has spent the most intervals resident.
- R6: With mode_i = 0 (spread), every buffer that was active when the interval started, other than the newcomer, first receives one slot, in ascending buffer order. All slots left after that go to the longest-resident active buffer.
- R7: Each arrival, from the (NBUF+1)-th on, produces exactly one output pulse in the following cycle. The pulse carries the code word that arrived NBUF intervals earlier: its arrival index, its pass flag (1 = passed) and the number of results received for it. No output pulse occurs for the first NBUF arrivals after reset.
- R8: A code word that has not passed by the time it is released is output with pass flag 0. Its iteration count is the number of iterations it actually received.
- R9: If no buffer is active when a slot comes up, the rest of that interval's slots go unused and no grant is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arrive_i | input | 1 | New code word, starts an interval; pulse only when the previous interval has ended |
| mode_i | input | 1 | Slot sharing: 1 oldest-only, 0 spread |
| grant_valid_o | output | 1 | One-cycle iteration grant |
| grant_buf_o | output | $clog2(NBUF) | Buffer granted |
| res_valid_i | input | 1 | Engine result for the outstanding grant |
| res_pass_i | input | 1 | Parity check passed |
| out_valid_o | output | 1 | Released code word valid |
| out_seq_o | output | SEQW | Arrival index of released code word |
| out_pass_o | output | 1 | Released code word passed |
| out_iters_o | output | ITW | Iterations received by released code word |

## Verification
The release pulse is registered on the arrival edge. It is therefore sampled on the falling edge that follows the cycle in which arrive_i is raised. The first grant of the interval is visible from that same falling edge onward. Each grant is sampled on the falling edge of its cycle. The bench raises the result on the next falling edge and drops it one cycle later, so each grant-to-result round trip takes exactly two cycles.

Two streams are run, one in each mode, with two slow code words and a mix of easy ones. The outputs are checked against expected iteration totals that differ between the modes. The number of grants in every interval is also checked, and that count reveals both the idle slots and the slots that are reassigned.

// File: rtl/iter_slot_sched.sv
module iter_slot_sched #(
  parameter int NBUF   = 8,
  parameter int BUDGET = 8,
  parameter int SEQW   = 8,
  parameter int ITW    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      arrive_i,
  input  logic                      mode_i,
  output logic                      grant_valid_o,
  output logic [$clog2(NBUF)-1:0]   grant_buf_o,
  input  logic                      res_valid_i,
  input  logic                      res_pass_i,
  output logic                      out_valid_o,
  output logic [SEQW-1:0]           out_seq_o,
  output logic                      out_pass_o,
  output logic [ITW-1:0]            out_iters_o
);
  localparam int BW = $clog2(NBUF);
  localparam int LW = $clog2(NBUF + 1);
  localparam int SW = $clog2(BUDGET + 1);

  typedef enum logic [1:0] {S_IDLE, S_GRANT, S_WAIT} st_t;
  st_t st;

  logic [NBUF-1:0] act, pas, filled, pend;
  logic [LW-1:0]   lat [NBUF];
  logic [ITW-1:0]  its [NBUF];
  logic [SEQW-1:0] sq  [NBUF];
  logic [BW-1:0]   wp, nb, gb;
  logic [SW-1:0]   slot;
  logic [SEQW-1:0] seq_cnt;

  logic            old_hit, pnd_hit, sel_hit, acc;
  logic [BW-1:0]   old_idx, pnd_idx, sel_idx;
  logic [LW-1:0]   old_lat;

  always_comb begin
    old_hit = 1'b0;
    old_idx = '0;
    old_lat = '0;
    pnd_hit = 1'b0;
    pnd_idx = '0;
    for (int i = 0; i < NBUF; i++) begin
      if (act[i] && (!old_hit || lat[i] > old_lat)) begin
        old_hit = 1'b1;
        old_idx = BW'(i);
        old_lat = lat[i];
      end
      if (!pnd_hit && pend[i] && act[i]) begin
        pnd_hit = 1'b1;
        pnd_idx = BW'(i);
      end
    end
  end

  assign acc     = arrive_i && (st == S_IDLE);
  assign sel_hit = (slot == '0) || (!mode_i && pnd_hit) || old_hit;
  assign sel_idx = (slot == '0) ? nb : (!mode_i && pnd_hit) ? pnd_idx : old_idx;

  assign grant_valid_o = (st == S_GRANT) && sel_hit;
  assign grant_buf_o   = sel_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      act         <= '0;
      pas         <= '0;
      filled      <= '0;
      pend        <= '0;
      wp          <= '0;
      nb          <= '0;
      gb          <= '0;
      slot        <= '0;
      seq_cnt     <= '0;
      out_valid_o <= 1'b0;
      out_seq_o   <= '0;
      out_pass_o  <= 1'b0;
      out_iters_o <= '0;
      for (int i = 0; i < NBUF; i++) begin
        lat[i] <= '0;
        its[i] <= '0;
        sq[i]  <= '0;
      end
    end else begin
      out_valid_o <= 1'b0;
      case (st)
        S_IDLE: if (arrive_i) begin
          out_valid_o <= filled[wp];
          out_seq_o   <= sq[wp];
          out_pass_o  <= pas[wp];
          out_iters_o <= its[wp];
          for (int i = 0; i < NBUF; i++) begin
            if (BW'(i) == wp) begin
              act[i]    <= 1'b1;
              pas[i]    <= 1'b0;
              filled[i] <= 1'b1;
              lat[i]    <= '0;
              its[i]    <= '0;
              sq[i]     <= seq_cnt;
            end else if (act[i]) begin
              lat[i] <= lat[i] + LW'(1);
            end
          end
          pend    <= act & ~(NBUF'(1) << wp);
          nb      <= wp;
          wp      <= (wp == BW'(NBUF - 1)) ? '0 : wp + BW'(1);
          seq_cnt <= seq_cnt + SEQW'(1);
          slot    <= '0;
          st      <= S_GRANT;
        end
        S_GRANT: if (sel_hit) begin
          gb            <= sel_idx;
          pend[sel_idx] <= 1'b0;
          slot          <= slot + SW'(1);
          st            <= S_WAIT;
        end else begin
          st <= S_IDLE;
        end
        S_WAIT: if (res_valid_i) begin
          its[gb] <= its[gb] + ITW'(1);
          pas[gb] <= res_pass_i;
          if (res_pass_i) act[gb] <= 1'b0;
          st <= (slot == SW'(BUDGET)) ? S_IDLE : S_GRANT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_grant_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |-> act[grant_buf_o]);

  p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid_o |=> !grant_valid_o);

  p_budget_r3: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= SW'(BUDGET));

  p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> grant_valid_o && grant_buf_o == $past(wp));

  p_release_timing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> $past(arrive_i));

  p_pass_has_iters_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o && out_pass_o |-> out_iters_o != '0);
endmodule

// File: tb/iter_slot_sched_bench.sv
module iter_slot_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int BG = 4;
  localparam int ROWS = 24;
  localparam int SLEN = 12;

  // {grants[21:18], mode[17], need[16:9], exp_pass[8], exp_iters[7:0]}
  localparam logic [21:0] TBL [ROWS] = '{
    {4'd4, 1'b1, 8'd100, 1'b0, 8'd13},
    {4'd4, 1'b1, 8'd100, 1'b0, 8'd4},
    {4'd4, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd4, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd4, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd3, 1'b1, 8'd3,   1'b1, 8'd3},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b1, 8'd1,   1'b1, 8'd1},
    {4'd4, 1'b0, 8'd100, 1'b0, 8'd11},
    {4'd4, 1'b0, 8'd100, 1'b0, 8'd6},
    {4'd4, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd4, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd4, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd3, 1'b0, 8'd3,   1'b1, 8'd3},
    {4'd2, 1'b0, 8'd2,   1'b1, 8'd2},
    {4'd1, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b0, 8'd1,   1'b1, 8'd1},
    {4'd1, 1'b0, 8'd1,   1'b1, 8'd1}
  };

  logic clk = 1'b0;
  logic rst_n, arrive, mode, res_valid, res_pass;
  logic grant_valid, out_valid, out_pass;
  logic [1:0] grant_buf;
  logic [7:0] out_seq, out_iters;

  int tests = 0, fails = 0, cyc = 0;
  int cnt [ROWS];
  bit done [ROWS];
  int bseq [NB];

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_slot_sched #(.NBUF(NB), .BUDGET(BG), .SEQW(8), .ITW(8)) u_iter_slot_sched (
    .clk(clk), .rst_n(rst_n), .arrive_i(arrive), .mode_i(mode),
    .grant_valid_o(grant_valid), .grant_buf_o(grant_buf),
    .res_valid_i(res_valid), .res_pass_i(res_pass),
    .out_valid_o(out_valid), .out_seq_o(out_seq),
    .out_pass_o(out_pass), .out_iters_o(out_iters));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; arrive = 1'b0; mode = 1'b0; res_valid = 1'b0; res_pass = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", int'(out_valid), 0);
    chk(!grant_valid, "R1 grant_valid", int'(grant_valid), 0);
  endtask

  task automatic run_row(input int row, input int loc);
    int grants = 0;
    bit first = 1'b1;
    int gb, r, base;
    bit p;
    base = row - loc;
    mode = TBL[row][17];
    arrive = 1'b1;
    @(negedge clk);
    arrive = 1'b0;
    if (loc >= NB) begin
      r = row - NB;
      chk(out_valid, "R7 release pulse", int'(out_valid), 1);
      chk(out_seq == 8'(loc - NB), "R7 release order", int'(out_seq), loc - NB);
      chk(out_pass == TBL[r][8], "R8 pass flag", int'(out_pass), int'(TBL[r][8]));
      chk(out_iters == TBL[r][7:0],
          TBL[r][17] ? "R5 oldest-only iterations" : "R6 spread iterations",
          int'(out_iters), int'(TBL[r][7:0]));
    end else begin
      chk(!out_valid, "R7 no release during fill", int'(out_valid), 0);
    end
    bseq[loc % NB] = row;
    repeat (BG + 3) begin
      if (grant_valid) begin
        gb = int'(grant_buf);
        r = bseq[gb];
        if (first) chk(gb == loc % NB, "R2 first grant buffer", gb, loc % NB);
        first = 1'b0;
        chk(!done[r], "R4 grant after pass", r - base, -1);
        grants++;
        cnt[r]++;
        p = (cnt[r] >= int'(TBL[r][16:9]));
        if (p) done[r] = 1'b1;
        @(negedge clk);
        chk(!grant_valid, "R3 one outstanding", int'(grant_valid), 0);
        res_valid = 1'b1; res_pass = p;
        @(negedge clk);
        res_valid = 1'b0; res_pass = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    chk(grants == int'(TBL[row][21:18]), "R3 R9 grants per interval",
        grants, int'(TBL[row][21:18]));
  endtask

  initial begin
    for (int i = 0; i < ROWS; i++) begin cnt[i] = 0; done[i] = 1'b0; end
    for (int i = 0; i < NB; i++) bseq[i] = 0;
    do_reset();
    for (int row = 0; row < ROWS; row++) begin
      if (row == SLEN) do_reset();
      run_row(row, row % SLEN);
    end
    // directed: arrival pulse after a reset mid-stream produces no stale release
    do_reset();
    arrive = 1'b1; mode = 1'b1;
    @(negedge clk);
    arrive = 1'b0;
    chk(!out_valid, "R7 no release after reset", int'(out_valid), 0);
    chk(grant_valid && grant_buf == 2'd0, "R2 buffer 0 after reset", int'(grant_buf), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule